// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

This block watches a wide bank of general-purpose input pins and forwards activity on a few of them to a parent interrupt controller. There are eight interrupt channels. Each channel picks one pin through a programmable index and passes that pin through a two-flop synchronizer and a programmable glitch filter. It then detects either a level or an edge on the result. Polarity is programmable. A per-channel both-edge mode fires on every transition and overrides the channel's single-edge and polarity settings.

The parent controller always receives a normalized signal. Level modes produce an active-high level on the channel output. All edge modes, whether rising, falling or both-edge, produce a one-cycle high pulse. Software sets up the channels through four 32-bit words on a simple write-strobe and address interface. Read data comes back one cycle after the address is presented.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset, every `irq_out` bit is 0 and all four configuration words read as 0.
- R2: The word map is as follows. Offset 0x0 holds trigger control, and only bits 23:0 are kept, so bits 31:24 read as 0. Offset 0x4 holds pin indices for channels 0 to 3. Offset 0x8 holds pin indices for channels 4 to 7. Offset 0xC holds filter settings. A write to a word lands on the clock edge where `reg_we` is high. `reg_rdata` shows the word addressed in the previous cycle.
- R3: The pin index of channel x is an 8-bit field at bits (x mod 4)*8+7 down to (x mod 4)*8. It lives in word 0x4 for x below 4 and in word 0x8 otherwise.
- R4: Channel x is in level mode when control bits x and 8+x are both 0. In level mode, `irq_out[x]` is high while the filtered pin is high if control bit 16+x is 0, and while it is low if bit 16+x is 1.
- R5: Channel x is in single-edge mode when control bit x is 1 and bit 8+x is 0. In this mode `irq_out[x]` gives one one-cycle pulse per rising transition if bit 16+x is 0, or per falling transition if bit 16+x is 1. The opposite transition gives nothing.
- R6: With control bit 8+x set, channel x pulses `irq_out[x]` for one cycle on every transition of the filtered pin, whatever bits x and 16+x hold.
- R7: A pin index of 100 or above never asserts `irq_out[x]` in any mode, including active-low level.
- R8: The filter setting of channel x is the 4-bit field at bits x*4+3 down to x*4 of word 0xC. A value N from 1 to 7 accepts a new pin value only after it has differed from the accepted value for N consecutive cycles. Values 8 to 15 behave as 7.
- R9: With a filter value of 0, a pin change that is present before a rising edge shows on `irq_out` after the fourth rising edge. In an edge mode the pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS (100) | Asynchronous GPIO pin levels |
| reg_we | input | 1 | Configuration write strobe |
| reg_addr | input | 4 | Byte offset of the configuration word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_out | output | NUM_CH (8) | Normalized interrupt lines to the parent controller |

## Verification
The bench targets the both-edge override. With the edge and polarity bits also set, a design that let them win would miss one of the two transitions. Out-of-range indices are driven in active-low level mode, where a design that read a zero from the empty part of the index space would raise a false interrupt. Glitches one cycle shorter than the filter length must be dropped and glitches of exactly that length passed. An off-by-one counter would pass the short glitch or drop the long one. Filter values above 7 and the exact four-edge latency are also probed, which catches a stage added to or missing from the pipeline.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int IDX_W     = 8;
  localparam int FLT_W     = 4;
  localparam int FLT_MAX   = 7;
  localparam int BOTH_OFS  = 8;
  localparam int LOW_OFS   = 16;

  localparam logic [ADDR_W-1:0] ADDR_CTL  = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_SEL0 = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_SEL1 = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_FLT  = 4'hC;

  localparam logic [DATA_W-1:0] CTL_MASK = 32'h00FF_FFFF;

  typedef struct packed {
    logic             edge_en;
    logic             act_low;
    logic             both;
    logic [FLT_W-1:0] flt;
    logic [IDX_W-1:0] idx;
  } chan_cfg_t;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] sel_lo_q,
  output logic [DATA_W-1:0] sel_hi_q,
  output logic [DATA_W-1:0] flt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      sel_lo_q <= '0;
      sel_hi_q <= '0;
      flt_q    <= '0;
    end else if (we) begin
      case (addr)
        ADDR_CTL:  ctl_q    <= wdata & CTL_MASK;
        ADDR_SEL0: sel_lo_q <= wdata;
        ADDR_SEL1: sel_hi_q <= wdata;
        ADDR_FLT:  flt_q    <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADDR_CTL:  rdata <= ctl_q;
        ADDR_SEL0: rdata <= sel_lo_q;
        ADDR_SEL1: rdata <= sel_hi_q;
        ADDR_FLT:  rdata <= flt_q;
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [CNT_W-1:0] limit,
  output logic             dout
);
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W:0]   run_nxt;

  assign run_nxt = {1'b0, run_cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b0;
      run_cnt <= '0;
    end else if (din == dout) begin
      run_cnt <= '0;
    end else if ((limit == '0) || (run_nxt >= {1'b0, limit})) begin
      dout    <= din;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_nxt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins,
  input  chan_cfg_t           cfg,
  output logic                irq
);
  localparam int SPAN  = 1 << IDX_W;
  localparam int CNT_W = $clog2(FLT_MAX + 1);

  logic [SPAN-1:0]  pin_span;
  logic             idx_ok;
  logic             pick;
  logic             sync_a, sync_b;
  logic             clean, clean_d;
  logic [CNT_W-1:0] lim;
  logic             hit;

  assign pin_span = SPAN'(pins);
  assign idx_ok   = 32'(cfg.idx) < NUM_PINS;
  assign pick     = idx_ok & pin_span[cfg.idx];
  assign lim      = (cfg.flt > FLT_W'(FLT_MAX)) ? CNT_W'(FLT_MAX) : cfg.flt[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= pick;
      sync_b <= sync_a;
    end
  end

  gpio_irq_filter #(.CNT_W(CNT_W)) filt_i (
    .clk  (clk),
    .rst  (rst),
    .din  (sync_b),
    .limit(lim),
    .dout (clean)
  );

  always_comb begin
    if (cfg.both)
      hit = clean ^ clean_d;
    else if (cfg.edge_en)
      hit = cfg.act_low ? (clean_d & ~clean) : (~clean_d & clean);
    else
      hit = clean ^ cfg.act_low;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clean_d <= 1'b0;
      irq     <= 1'b0;
    end else begin
      clean_d <= clean;
      irq     <= idx_ok & hit;
    end
  end
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 100,
  parameter int NUM_CH   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [NUM_CH-1:0]   irq_out
);
  localparam int CPW = DATA_W / IDX_W;

  logic [DATA_W-1:0] ctl_q, sel_lo_q, sel_hi_q, flt_q;

  gpio_irq_regs regs_i (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .ctl_q   (ctl_q),
    .sel_lo_q(sel_lo_q),
    .sel_hi_q(sel_hi_q),
    .flt_q   (flt_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_cfg_t cfg;
    if (c < CPW) begin : g_lo
      assign cfg.idx = sel_lo_q[(c % CPW)*IDX_W +: IDX_W];
    end else begin : g_hi
      assign cfg.idx = sel_hi_q[(c % CPW)*IDX_W +: IDX_W];
    end
    assign cfg.edge_en = ctl_q[c];
    assign cfg.both    = ctl_q[BOTH_OFS + c];
    assign cfg.act_low = ctl_q[LOW_OFS + c];
    assign cfg.flt     = flt_q[c*FLT_W +: FLT_W];

    gpio_irq_chan #(.NUM_PINS(NUM_PINS)) chan_i (
      .clk (clk),
      .rst (rst),
      .pins(pin_in),
      .cfg (cfg),
      .irq (irq_out[c])
    );
  end
endmodule

// File: rtl/gpio_irq_mux_chk.sv
module gpio_irq_mux_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 100,
  parameter int NUM_CH   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NUM_CH-1:0] irq_out,
  input logic [DATA_W-1:0] ctl_q,
  input logic [DATA_W-1:0] sel_lo_q,
  input logic [DATA_W-1:0] sel_hi_q
);
  localparam int CPW = DATA_W / IDX_W;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (irq_out == '0)); // R1

  AST_CTL_READBACK: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_CTL) ##1 (!reg_we && reg_addr == ADDR_CTL)
    |=> (reg_rdata == ($past(reg_wdata, 2) & CTL_MASK))); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [IDX_W-1:0] idx_v;
    logic             bad_idx;
    logic             single_edge;
    if (c < CPW) begin : g_lo
      assign idx_v = sel_lo_q[(c % CPW)*IDX_W +: IDX_W];
    end else begin : g_hi
      assign idx_v = sel_hi_q[(c % CPW)*IDX_W +: IDX_W];
    end
    assign bad_idx     = 32'(idx_v) >= NUM_PINS;
    assign single_edge = ctl_q[c] & ~ctl_q[BOTH_OFS + c];

    AST_BAD_INDEX_QUIET: assert property (@(posedge clk) disable iff (rst)
      bad_idx |=> !irq_out[c]); // R7

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (irq_out[c] && single_edge && $past(single_edge)) |=> !irq_out[c]); // R5
  end
endmodule

bind gpio_irq_mux gpio_irq_mux_chk #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .irq_out  (irq_out),
  .ctl_q    (ctl_q),
  .sel_lo_q (sel_lo_q),
  .sel_hi_q (sel_hi_q)
);

// File: tb/gpio_irq_mux_tb.sv
module gpio_irq_mux_tb_top;
  localparam int NP = 100;
  localparam int NC = 8;
  localparam int WIN = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_in = '0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] irq_out;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  gpio_irq_mux #(.NUM_PINS(NP), .NUM_CH(NC)) dut_i (
    .clk(clk), .rst(rst), .pin_in(pin_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  typedef struct packed {
    logic [2:0] ch;
    logic       edg;
    logic       low;
    logic       both;
    logic [7:0] idx;
    logic [3:0] flt;
    logic       st;
    logic       en;
    logic [1:0] rises;
    logic       fin;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 1'b0, 1'b0, 8'd5,   4'd0,  1'b0, 1'b1, 2'd1, 1'b1}, // R4 high level
    '{3'd1, 1'b0, 1'b1, 1'b0, 8'd17,  4'd0,  1'b1, 1'b0, 2'd1, 1'b1}, // R4 low level asserts
    '{3'd2, 1'b0, 1'b1, 1'b0, 8'd30,  4'd0,  1'b0, 1'b1, 2'd0, 1'b0}, // R4 low level releases
    '{3'd3, 1'b1, 1'b0, 1'b0, 8'd40,  4'd0,  1'b0, 1'b1, 2'd1, 1'b0}, // R5 rising fires
    '{3'd4, 1'b1, 1'b0, 1'b0, 8'd41,  4'd0,  1'b1, 1'b0, 2'd0, 1'b0}, // R5 rising ignores fall
    '{3'd5, 1'b1, 1'b1, 1'b0, 8'd60,  4'd0,  1'b1, 1'b0, 2'd1, 1'b0}, // R5 falling fires
    '{3'd6, 1'b1, 1'b1, 1'b0, 8'd61,  4'd0,  1'b0, 1'b1, 2'd0, 1'b0}, // R5 falling ignores rise
    '{3'd7, 1'b1, 1'b1, 1'b1, 8'd99,  4'd0,  1'b0, 1'b1, 2'd1, 1'b0}, // R6 rise overrides
    '{3'd7, 1'b1, 1'b1, 1'b1, 8'd99,  4'd0,  1'b1, 1'b0, 2'd1, 1'b0}, // R6 fall overrides
    '{3'd0, 1'b0, 1'b0, 1'b1, 8'd2,   4'd0,  1'b1, 1'b0, 2'd1, 1'b0}, // R6 over level
    '{3'd1, 1'b0, 1'b1, 1'b0, 8'd100, 4'd0,  1'b1, 1'b0, 2'd0, 1'b0}, // R7 index 100
    '{3'd2, 1'b0, 1'b1, 1'b0, 8'd223, 4'd0,  1'b1, 1'b0, 2'd0, 1'b0}, // R7 index 223
    '{3'd6, 1'b0, 1'b0, 1'b0, 8'd70,  4'd7,  1'b0, 1'b1, 2'd1, 1'b1}, // R8 filter 7
    '{3'd5, 1'b0, 1'b0, 1'b0, 8'd3,   4'd15, 1'b0, 1'b1, 2'd1, 1'b1}  // R8 filter 15 clamps
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic cfg(input int ch, input logic edg, input logic low, input logic both,
                     input logic [7:0] idx, input logic [3:0] flt);
    logic [31:0] c;
    c = ({31'b0, edg} << ch) | ({31'b0, both} << (8 + ch)) | ({31'b0, low} << (16 + ch));
    wr(4'h0, c);
    if (ch < 4) begin
      wr(4'h4, {24'b0, idx} << (ch * 8));
      wr(4'h8, 32'h0);
    end else begin
      wr(4'h4, 32'h0);
      wr(4'h8, {24'b0, idx} << ((ch - 4) * 8));
    end
    wr(4'hC, {28'b0, flt} << (ch * 4));
  endtask

  task automatic observe(input int ch, input int n, output int rises, output logic fin);
    logic prv;
    prv = irq_out[ch];
    rises = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (irq_out[ch] && !prv) rises++;
      prv = irq_out[ch];
    end
    fin = irq_out[ch];
  endtask

  initial begin
    logic [31:0] d;
    int r;
    logic f;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {24'b0, irq_out}, 32'h0);
    rd(4'h0, d); check("R1 ctl", d, 32'h0);
    rd(4'h4, d); check("R1 sel0", d, 32'h0);
    rd(4'h8, d); check("R1 sel1", d, 32'h0);
    rd(4'hC, d); check("R1 flt", d, 32'h0);

    // R2 readback and masking
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, d); check("R2 ctl mask", d, 32'h00FF_FFFF);
    wr(4'h4, 32'h6463_6261); rd(4'h4, d); check("R2 sel0", d, 32'h6463_6261);
    wr(4'h8, 32'hA5C3_E1F0); rd(4'h8, d); check("R2 sel1", d, 32'hA5C3_E1F0);
    wr(4'hC, 32'h7654_3210); rd(4'hC, d); check("R2 flt", d, 32'h7654_3210);

    // Vector table: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      pin_in = '0;
      pin_in[VEC[v].idx < NP ? VEC[v].idx : 0] = VEC[v].st;
      cfg(int'(VEC[v].ch), VEC[v].edg, VEC[v].low, VEC[v].both, VEC[v].idx, VEC[v].flt);
      repeat (WIN) @(negedge clk);
      if (VEC[v].idx < NP) pin_in[VEC[v].idx] = VEC[v].en;
      else pin_in = {NP{VEC[v].en}};
      observe(int'(VEC[v].ch), WIN, r, f);
      check($sformatf("vector %0d rises", v), r, {30'b0, VEC[v].rises});
      check($sformatf("vector %0d final", v), {31'b0, f}, {31'b0, VEC[v].fin});
    end

    // R3 field position in word 0x8: channel 5 takes bits 15:8
    pin_in = '0;
    pin_in[50] = 1'b1;
    wr(4'h0, 32'h0);
    wr(4'hC, 32'h0);
    wr(4'h8, 32'h0000_3200);
    repeat (WIN) @(negedge clk);
    check("R3 ch5 follows pin 50", {31'b0, irq_out[5]}, 32'h1);
    check("R3 ch4 stays on pin 0", {31'b0, irq_out[4]}, 32'h0);

    // R8 glitch two cycles rejected, three accepted with N=3
    pin_in = '0;
    cfg(0, 1'b0, 1'b0, 1'b0, 8'd8, 4'd3);
    repeat (WIN) @(negedge clk);
    pin_in[8] = 1'b1; repeat (2) @(negedge clk); pin_in[8] = 1'b0;
    observe(0, WIN, r, f);
    check("R8 short glitch dropped", r, 0);
    pin_in[8] = 1'b1; repeat (3) @(negedge clk); pin_in[8] = 1'b0;
    observe(0, WIN, r, f);
    check("R8 full-length glitch kept", r, 1);

    // R9 latency, level mode
    pin_in = '0;
    cfg(0, 1'b0, 1'b0, 1'b0, 8'd9, 4'd0);
    repeat (WIN) @(negedge clk);
    pin_in[9] = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 level before edge 4", {31'b0, irq_out[0]}, 32'h0);
    @(negedge clk);
    check("R9 level after edge 4", {31'b0, irq_out[0]}, 32'h1);

    // R9 latency and width, rising edge mode
    pin_in = '0;
    cfg(0, 1'b1, 1'b0, 1'b0, 8'd9, 4'd0);
    repeat (WIN) @(negedge clk);
    pin_in[9] = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 pulse before edge 4", {31'b0, irq_out[0]}, 32'h0);
    @(negedge clk);
    check("R9 pulse after edge 4", {31'b0, irq_out[0]}, 32'h1);
    @(negedge clk);
    check("R9 pulse one cycle", {31'b0, irq_out[0]}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule